// File: doc/BRIEF.md
# Shadow-Loaded PWM Channel

This block generates one pulse-width modulated output from a 16-bit counter, an active period value and an active width value. Software never writes the active values directly: it writes a staging copy of each through a small write port, and the staging copies are transferred into the active registers only at the instant the counter restarts a cycle, so a change never produces a truncated or doubled pulse.

Two counting shapes are offered. In edge mode the counter climbs from zero and clears after it reaches the period value. In centre mode it climbs to the period value and then falls back to zero, so for the same period value the output repeats at roughly half the rate and the pulse sits symmetrically in the cycle. The counter advances on a tick that is either every clock or one clock in a parameter-set number (64 by default). The output is high while the counter is at or above the width value, is forced low when the output enable is off, and a one-cycle flag marks every cycle restart.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset the output `pwm_out` and `period_flag` are 0, the counter is 0 and counting upward, and the staging and active period and width values are all 0.
- R2: In edge mode (`center_mode`=0) each tick raises the counter by one, and a tick that finds the counter at or above the active period P clears it to 0 (a restart), so a cycle lasts P+1 ticks.
- R3: In centre mode (`center_mode`=1) the counter rises from 0 to P and then falls back; the tick that brings it to 0 is the restart, so a cycle lasts 2P ticks (P=0: the counter stays 0 and every tick is a restart).
- R4: `pwm_out` is a register that, one clock after the counter holds value C and the active width is W, is 1 exactly when C >= W and `out_en` was 1.
- R5: An active width of 0 gives a constant high output; an active width above P gives a constant low output.
- R6: When `out_en` is 0, `pwm_out` is 0 from the next clock on.
- R7: A write with `wr_en`=1 stores `wr_data` into the staging period when `wr_sel`=0 and into the staging width when `wr_sel`=1; the active values take the staging values only on a restart, or on any clock where `run` is 0 and the counter is 0. A write mid-cycle leaves the running cycle unchanged; a write on the restart clock lands at the following restart.
- R8: With `psc_sel`=0 the counter ticks on every clock where `run` is 1; with `psc_sel`=1 it ticks once every PSC_DIV clocks of `run`, so cycle length in clocks is the tick count times PSC_DIV.
- R9: While `run` is 0 there are no ticks: the counter and direction hold, no restart or flag occurs, and the prescaler count clears.
- R10: `period_flag` is high for the clock following each restart tick, during which the counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Staging register write strobe |
| wr_sel | input | 1 | Write target: 0 period, 1 width |
| wr_data | input | CNT_W | Value to write |
| run | input | 1 | Counter runs when 1 |
| center_mode | input | 1 | 0 edge mode, 1 centre mode |
| psc_sel | input | 1 | 0 tick every clock, 1 tick every PSC_DIV clocks |
| out_en | input | 1 | Output enable |
| pwm_out | output | 1 | Registered PWM output |
| period_flag | output | 1 | One-clock pulse after each restart |

## Verification
The main function is swept over every combination of the two counting shapes, period values 0 to 5 and width values 0 to 7, measuring the clocks between flags and the high clocks in one cycle; the cycle length separates the edge and centre counting shapes and their end points, while the high count separates an off-by-one in the width compare, including the width-zero and width-above-period ends. A slow-prescaler run in each shape tells a tick that is gated correctly from one that advances every clock. A mid-cycle rewrite of both values tells a shadow transfer at the restart apart from an immediate one, and pausing and disabling cases show the counter and output hold or drop as required.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_WIDTH  = 1'b1
  } pwm_wsel_e;

  localparam int NUM_SHADOW = 2;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSC_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic psc_sel,
  output logic tick
);
  localparam int PC_W = (PSC_DIV > 2) ? $clog2(PSC_DIV) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PSC_DIV - 1);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst || !run || !psc_sel) begin
      pc_q <= '0;
    end else if (pc_q == PC_LAST) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

  always_comb begin
    tick = run && (!psc_sel || (pc_q == PC_LAST));
  end
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load,
  output logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] wid_act
);
  logic [CNT_W-1:0] stage_q [NUM_SHADOW];
  logic [CNT_W-1:0] act_q   [NUM_SHADOW];

  for (genvar i = 0; i < NUM_SHADOW; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[i] <= '0;
        act_q[i]   <= '0;
      end else begin
        if (wr_en && (wr_sel == 1'(i))) begin
          stage_q[i] <= wr_data;
        end
        if (load) begin
          act_q[i] <= stage_q[i];
        end
      end
    end
  end

  always_comb begin
    per_act = act_q[SEL_PERIOD];
    wid_act = act_q[SEL_WIDTH];
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             center_mode,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt_q,
  output logic             restart,
  output logic             flag_q
);
  logic             down_q;
  logic             down_n;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n   = cnt_q;
    down_n  = down_q;
    restart = 1'b0;
    if (tick) begin
      if (!center_mode) begin
        down_n = 1'b0;
        if (cnt_q >= per_act) begin
          cnt_n   = '0;
          restart = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        if (!down_q) begin
          if (cnt_q < per_act) begin
            cnt_n = cnt_q + 1'b1;
          end else if (cnt_q != '0) begin
            cnt_n  = cnt_q - 1'b1;
            down_n = 1'b1;
          end else begin
            cnt_n = '0;
          end
        end else if (cnt_q != '0) begin
          cnt_n = cnt_q - 1'b1;
        end
        if (cnt_n == '0) begin
          restart = 1'b1;
          down_n  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
      flag_q <= restart;
    end
  end
endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             out_en,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] wid_act,
  output logic             pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= out_en && (cnt_q >= wid_act);
    end
  end
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan #(
  parameter int CNT_W   = 16,
  parameter int PSC_DIV = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             run,
  input  logic             center_mode,
  input  logic             psc_sel,
  input  logic             out_en,
  output logic             pwm_out,
  output logic             period_flag
);
  logic             tick;
  logic             restart;
  logic             load;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_act;
  logic [CNT_W-1:0] wid_act;

  pwm_prescaler #(.PSC_DIV(PSC_DIV)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .psc_sel (psc_sel),
    .tick    (tick)
  );

  always_comb begin
    load = restart || (!run && (cnt_q == '0));
  end

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .load    (load),
    .per_act (per_act),
    .wid_act (wid_act)
  );

  pwm_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .center_mode (center_mode),
    .per_act     (per_act),
    .cnt_q       (cnt_q),
    .restart     (restart),
    .flag_q      (period_flag)
  );

  pwm_outstage #(.CNT_W(CNT_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .out_en  (out_en),
    .cnt_q   (cnt_q),
    .wid_act (wid_act),
    .pwm_q   (pwm_out)
  );
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             out_en,
  input logic             pwm_out,
  input logic             period_flag,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W-1:0] wid_act
);
  assert_flag_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
    period_flag |-> $past(run));

  assert_hold_when_stopped_R9: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt_q));

  assert_low_when_off_R6: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !pwm_out);

  assert_load_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(per_act) || !$stable(wid_act)) |-> (cnt_q == '0));

  assert_flag_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
    period_flag |-> (cnt_q == '0));

  assert_zero_width_high_R5: assert property (@(posedge clk) disable iff (rst)
    (out_en && (wid_act == '0)) |=> pwm_out);
endmodule

bind pwm_shadow_chan pwm_chan_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run         (run),
  .out_en      (out_en),
  .pwm_out     (pwm_out),
  .period_flag (period_flag),
  .cnt_q       (cnt_q),
  .per_act     (per_act),
  .wid_act     (wid_act)
);

// File: tb/sim_pwm_shadow_chan.sv
module sim_pwm_shadow_chan;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int PSC_DIV    = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic             wr_sel = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             run = 1'b0;
  logic             center_mode = 1'b0;
  logic             psc_sel = 1'b0;
  logic             out_en = 1'b0;
  logic             pwm_out;
  logic             period_flag;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_shadow_chan #(.CNT_W(CNT_W), .PSC_DIV(PSC_DIV)) u0 (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .run (run), .center_mode (center_mode), .psc_sel (psc_sel), .out_en (out_en),
    .pwm_out (pwm_out), .period_flag (period_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int ticks_of(input int mode, input int p);
    if (mode == 0) return p + 1;
    return (p == 0) ? 1 : 2 * p;
  endfunction

  function automatic int high_of(input int mode, input int p, input int w);
    int h = 0;
    if (mode == 0) begin
      for (int c = 0; c <= p; c++) if (c >= w) h++;
    end else if (p == 0) begin
      h = (w == 0) ? 1 : 0;
    end else begin
      for (int c = 0; c <= p; c++) if (c >= w) h++;
      for (int c = 1; c < p; c++) if (c >= w) h++;
    end
    return h;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_reg(input logic sel, input int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = CNT_W'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_flag(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (period_flag) begin ok = 1'b1; break; end
    end
  endtask

  task automatic measure(output int len, output int hi);
    bit ok;
    len = 0; hi = 0;
    wait_flag(ok);
    if (!ok) begin len = -1; return; end
    do begin
      @(negedge clk);
      len++;
      hi += int'(pwm_out);
    end while (!period_flag && len < 20000);
  endtask

  task automatic setup(input int mode, input int p, input int w, input bit slow, input bit en);
    do_reset();
    center_mode = mode[0]; psc_sel = slow; out_en = en;
    write_reg(1'b0, p);
    write_reg(1'b1, w);
    @(negedge clk);
    run = 1'b1;
  endtask

  initial begin
    int len, hi;
    bit ok;
    logic held;
    do_reset();
    // R1: reset state
    check("R1 pwm_out after reset", int'(pwm_out), 0);
    check("R1 period_flag after reset", int'(period_flag), 0);

    // R2 R3 R4 R5: sweep of shape, period and width
    for (int mode = 0; mode < 2; mode++) begin
      for (int p = 0; p <= 5; p++) begin
        for (int w = 0; w <= 7; w++) begin
          setup(mode, p, w, 1'b0, 1'b1);
          measure(len, hi);
          check(mode == 0 ? "R2 edge cycle length" : "R3 centre cycle length",
                len, ticks_of(mode, p));
          if (w == 0 || w > p)
            check("R5 constant level high count", hi, high_of(mode, p, w));
          else
            check("R4 high clocks per cycle", hi, high_of(mode, p, w));
        end
      end
    end

    // R8: slow prescaler in both shapes
    for (int mode = 0; mode < 2; mode++) begin
      setup(mode, 2, 1, 1'b1, 1'b1);
      measure(len, hi);
      check("R8 slow cycle length", len, ticks_of(mode, 2) * PSC_DIV);
      check("R8 slow high clocks", hi, high_of(mode, 2, 1) * PSC_DIV);
    end

    // R6: output disabled with width 0
    setup(0, 4, 0, 1'b0, 1'b0);
    measure(len, hi);
    check("R6 disabled output high clocks", hi, 0);
    check("R6 disabled cycle length", len, 5);

    // R7: mid-cycle rewrite waits for the restart
    setup(0, 9, 3, 1'b0, 1'b1);
    wait_flag(ok);
    len = 0; hi = 0;
    do begin
      if (len == 2) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = CNT_W'(4); end
      if (len == 3) begin wr_en = 1'b1; wr_sel = 1'b1; wr_data = CNT_W'(7); end
      if (len == 4) wr_en = 1'b0;
      @(negedge clk);
      len++;
      hi += int'(pwm_out);
    end while (!period_flag && len < 1000);
    check("R7 running cycle keeps old period", len, 10);
    check("R7 running cycle keeps old width", hi, high_of(0, 9, 3));
    len = 0; hi = 0;
    do begin
      @(negedge clk);
      len++;
      hi += int'(pwm_out);
    end while (!period_flag && len < 1000);
    check("R7 next cycle new period", len, 5);
    check("R7 next cycle new width", hi, high_of(0, 4, 7));

    // R9: pause holds counter and output, no flags
    setup(0, 9, 4, 1'b0, 1'b1);
    wait_flag(ok);
    repeat (6) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    held = pwm_out;
    len = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (period_flag || pwm_out != held) len++;
    end
    check("R9 no flag or output change while stopped", len, 0);
    run = 1'b1;
    len = 0;
    do begin @(negedge clk); len++; end while (!period_flag && len < 1000);
    // counter at 6 when stopped (flag cycle = 0, six ticks): 4 ticks remain
    check("R9 resume continues from held count", len, 4);

    // R10: flag is a single clock when cycles are longer than one tick
    setup(1, 3, 2, 1'b0, 1'b1);
    wait_flag(ok);
    @(negedge clk);
    check("R10 flag lasts one clock", int'(period_flag), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule